// File: doc/BRIEF.md
# Dual-Clock Retransmit FIFO

This block is a first-in first-out buffer of 18-bit words. Its write port and read port each run on their own clock, and those clocks may be free-running or irregular. A word is stored on a write-clock rising edge when the write enable is high and the buffer is not full. A word is fetched on a read-clock rising edge when the read enable is high and the buffer is not empty. Each side sees the other side's position through a Gray-coded pointer that passes through a two-flop synchronizer.

The block reports five fill flags. Full, almost-full and half-full are computed in the write domain. Empty and almost-empty are computed in the read domain. The two "almost" margins are inputs driven by a separate register block.

An active-high retransmit request moves the read pointer back to address zero and leaves the write pointer where it is. This lets the data between address zero and the write position be read out again as often as needed. A request is honoured only while the write pointer has never wrapped past the last address since reset, and a static enable input can turn the feature off. After a rewind, the block reports empty for two read cycles and accepts no read during that time.

Top module: `rtx_fifo`

## Requirements
- R1: Words come out on `rd_data` in the order they were written. `rd_data` is a register that takes the next word at the read-clock edge that accepts a read and holds it until the next accepted read.
- R2: While `rst` is high, both pointers clear. After reset, `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `half_full`=0.
- R3: A write while `full`=1 is dropped and changes no stored word. A read while `empty`=1 is dropped and leaves `rd_data` unchanged.
- R4: `full` is 1 when DEPTH words are stored. `half_full` is 1 when more than DEPTH/2 words are stored.
- R5: `almost_full` is 1 when the free space (DEPTH minus the stored count) is at or below `af_level`. `almost_empty` is 1 when the stored count is at or below `ae_level`.
- R6: A read-clock edge with `rt_req`=1 that is accepted sets the read pointer to address 0 and leaves the write pointer unchanged. The stored block is then read again from its first word, and this can repeat any number of times.
- R7: Once a write has gone to the last address (DEPTH-1) since reset, every later `rt_req` is ignored until the next reset.
- R8: While `rt_allow`=0, `rt_req` has no effect.
- R9: For the two read cycles after an accepted retransmit, `empty` and `almost_empty` are forced to 1 and read enables are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock |
| rclk | input | 1 | Read-port clock |
| rst | input | 1 | Synchronous active-high reset, held across several edges of both clocks |
| wr_en | input | 1 | Write enable |
| wr_data | input | 18 | Word to store |
| rd_en | input | 1 | Read enable |
| rd_data | output | 18 | Registered read word |
| rt_req | input | 1 | Retransmit request, read-clock domain |
| rt_allow | input | 1 | Tie-off enable for retransmit |
| af_level | input | log2(DEPTH) | Almost-full margin, in free words |
| ae_level | input | log2(DEPTH) | Almost-empty margin, in stored words |
| full | output | 1 | Buffer holds DEPTH words |
| almost_full | output | 1 | Free space at or below `af_level` |
| half_full | output | 1 | More than DEPTH/2 words stored |
| almost_empty | output | 1 | Stored count at or below `ae_level` |
| empty | output | 1 | No word available to read |

## Verification
Plain bursts with distinct word values check that order is kept. A fill that steps the count one word at a time checks that each flag switches at its exact threshold rather than one word early or late. An overfill followed by a full drain, and reads issued on an empty buffer, show whether dropped operations truly leave the stored data and `rd_data` untouched. Retransmit is tried in four cases: a partial read, a repeated replay, a disabled tie-off, and a buffer that has already wrapped. In the wrapped case the word at address zero differs from the next queued word, so an accepted rewind cannot be mistaken for an ignored one.

// File: rtl/rtxf_pkg.sv
`timescale 1ns/1ps
package rtxf_pkg;
    localparam int WORD_W     = 18;
    localparam int SETTLE_CYC = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic half_full;
    } wflags_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
    } rflags_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction
endpackage

// File: rtl/rtxf_sync.sv
`timescale 1ns/1ps
module rtxf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rtxf_mem.sv
`timescale 1ns/1ps
module rtxf_mem
    import rtxf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/rtxf_wr.sv
`timescale 1ns/1ps
module rtxf_wr
    import rtxf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_s,
    input  logic [AW-1:0] af_level,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] wgray,
    output logic          wr_fire,
    output logic          wrapped,
    output wflags_t       flags
);
    logic [PW-1:0] rbin_s, count, free;

    assign rbin_s = PW'(gray2bin(32'(rgray_s)));
    assign count  = wptr - rbin_s;
    assign free   = PW'(DEPTH) - count;

    always_comb begin
        flags.full        = (count == PW'(DEPTH));
        flags.almost_full = (free <= {1'b0, af_level});
        flags.half_full   = (count > PW'(DEPTH / 2));
    end

    assign wr_fire = wr_en & ~flags.full;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            wgray   <= '0;
            wrapped <= 1'b0;
        end else if (wr_fire) begin
            wptr  <= wptr + 1'b1;
            wgray <= PW'(bin2gray(32'(wptr + 1'b1)));
            if (wptr[AW-1:0] == '1) wrapped <= 1'b1;
        end
    end
endmodule

// File: rtl/rtxf_rd.sv
`timescale 1ns/1ps
module rtxf_rd
    import rtxf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          rt_req,
    input  logic          rt_allow,
    input  logic          wrapped_s,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] ae_level,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] rgray,
    output logic          rd_fire,
    output logic          rt_fire,
    output rflags_t       flags
);
    logic [PW-1:0] wbin_s, count;
    logic [1:0]    settle;
    logic          settling;

    assign wbin_s   = PW'(gray2bin(32'(wgray_s)));
    assign count    = wbin_s - rptr;
    assign settling = (settle != 2'd0);

    always_comb begin
        flags.empty        = (count == '0) | settling;
        flags.almost_empty = (count <= {1'b0, ae_level}) | settling;
    end

    assign rt_fire = rt_req & rt_allow & ~wrapped_s;
    assign rd_fire = rd_en & ~flags.empty & ~rt_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr   <= '0;
            rgray  <= '0;
            settle <= '0;
        end else if (rt_fire) begin
            rptr   <= '0;
            rgray  <= '0;
            settle <= 2'(SETTLE_CYC);
        end else begin
            if (settling) settle <= settle - 2'd1;
            if (rd_fire) begin
                rptr  <= rptr + 1'b1;
                rgray <= PW'(bin2gray(32'(rptr + 1'b1)));
            end
        end
    end
endmodule

// File: rtl/rtx_fifo.sv
`timescale 1ns/1ps
module rtx_fifo
    import rtxf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [17:0]   wr_data,
    input  logic          rd_en,
    output logic [17:0]   rd_data,
    input  logic          rt_req,
    input  logic          rt_allow,
    input  logic [AW-1:0] af_level,
    input  logic [AW-1:0] ae_level,
    output logic          full,
    output logic          almost_full,
    output logic          half_full,
    output logic          almost_empty,
    output logic          empty
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
    logic [PW-1:0] wgray_at_r, rgray_at_w;
    logic          wr_fire, rd_fire, rt_fire;
    logic          wrapped_w, wrapped_r;
    wflags_t       wfl;
    rflags_t       rfl;

    rtxf_wr #(.DEPTH(DEPTH)) u_wr (
        .clk(wclk), .rst(rst), .wr_en(wr_en), .rgray_s(rgray_at_w),
        .af_level(af_level), .wptr(wptr_bin), .wgray(wptr_gray),
        .wr_fire(wr_fire), .wrapped(wrapped_w), .flags(wfl)
    );

    rtxf_rd #(.DEPTH(DEPTH)) u_rd (
        .clk(rclk), .rst(rst), .rd_en(rd_en), .rt_req(rt_req),
        .rt_allow(rt_allow), .wrapped_s(wrapped_r), .wgray_s(wgray_at_r),
        .ae_level(ae_level), .rptr(rptr_bin), .rgray(rptr_gray),
        .rd_fire(rd_fire), .rt_fire(rt_fire), .flags(rfl)
    );

    rtxf_sync #(.W(PW)) u_sync_r2w (
        .clk(wclk), .rst(rst), .d(rptr_gray), .q(rgray_at_w)
    );

    rtxf_sync #(.W(PW + 1)) u_sync_w2r (
        .clk(rclk), .rst(rst), .d({wrapped_w, wptr_gray}),
        .q({wrapped_r, wgray_at_r})
    );

    rtxf_mem #(.DEPTH(DEPTH)) u_mem (
        .wclk(wclk), .we(wr_fire), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data),
        .rclk(rclk), .re(rd_fire), .raddr(rptr_bin[AW-1:0]), .rdata(rd_data)
    );

    assign full         = wfl.full;
    assign almost_full  = wfl.almost_full;
    assign half_full    = wfl.half_full;
    assign empty        = rfl.empty;
    assign almost_empty = rfl.almost_empty;
endmodule

// File: rtl/rtxf_chk.sv
`timescale 1ns/1ps
module rtxf_chk #(
    parameter int PW = 12
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          almost_full,
    input logic          half_full,
    input logic          empty,
    input logic          almost_empty,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr,
    input logic          rt_fire,
    input logic          wrapped
);
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (rst)
        full && wr_en |=> $stable(wptr)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rst)
        empty && rd_en && !rt_fire |=> $stable(rptr)); // R3
    AST_FULL_FLAGS: assert property (@(posedge wclk) disable iff (rst)
        full |-> almost_full && half_full); // R4
    AST_EMPTY_FLAGS: assert property (@(posedge rclk) disable iff (rst)
        empty |-> almost_empty); // R5
    AST_RT_REWIND: assert property (@(posedge rclk) disable iff (rst)
        rt_fire |=> rptr == '0); // R6
    AST_WRAP_STICKY: assert property (@(posedge wclk) disable iff (rst)
        wrapped |=> wrapped); // R7
    AST_RT_SETTLE: assert property (@(posedge rclk) disable iff (rst)
        rt_fire |=> empty && almost_empty); // R9
endmodule

bind rtx_fifo rtxf_chk #(.PW(PW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .full(full), .almost_full(almost_full), .half_full(half_full),
    .empty(empty), .almost_empty(almost_empty), .wptr(wptr_bin),
    .rptr(rptr_bin), .rt_fire(rt_fire), .wrapped(wrapped_w)
);

// File: tb/rtx_fifo_bench.sv
`timescale 1ns/1ps
module rtx_fifo_bench;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0, rt_req = 1'b0, rt_allow = 1'b1;
    logic [17:0] wr_data = '0, rd_data;
    logic [AW-1:0] af_level = AW'(3), ae_level = AW'(2);
    logic full, almost_full, half_full, almost_empty, empty;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 wclk = ~wclk;
    always #6.5 rclk = ~rclk;

    rtx_fifo #(.DEPTH(DEPTH)) u_rtx_fifo (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rt_req(rt_req), .rt_allow(rt_allow),
        .af_level(af_level), .ae_level(ae_level), .full(full),
        .almost_full(almost_full), .half_full(half_full),
        .almost_empty(almost_empty), .empty(empty)
    );

    function automatic logic [17:0] w(input int i);
        return 18'(i * 18'h0135 + 18'h2A00);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge wclk); rst = 1'b1;
        repeat (4) @(posedge rclk);
        @(negedge wclk); rst = 1'b0;
        settle();
    endtask

    task automatic settle();
        repeat (6) @(posedge wclk);
        repeat (6) @(posedge rclk);
        @(negedge rclk);
    endtask

    task automatic push(input logic [17:0] d);
        @(negedge wclk); wr_en = 1'b1; wr_data = d;
        @(negedge wclk); wr_en = 1'b0;
    endtask

    task automatic pop(output logic [17:0] d);
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic pulse_rt();
        @(negedge rclk); rt_req = 1'b1;
        @(negedge rclk); rt_req = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R2 empty", 32'(empty), 1);
        check("R2 almost_empty", 32'(almost_empty), 1);
        check("R2 full", 32'(full), 0);
        check("R2 almost_full", 32'(almost_full), 0);
        check("R2 half_full", 32'(half_full), 0);
    endtask

    task automatic t_order();
        logic [17:0] d;
        do_reset();
        for (int i = 0; i < 5; i++) push(w(i) ^ 18'h3F0F0);
        settle();
        check("R1 not empty", 32'(empty), 0);
        for (int i = 0; i < 5; i++) begin
            pop(d);
            check("R1 order", 32'(d), 32'(w(i) ^ 18'h3F0F0));
        end
        settle();
        check("R1 drained", 32'(empty), 1);
    endtask

    task automatic t_levels();
        logic [17:0] d, last;
        do_reset();
        for (int i = 0; i < 2; i++) push(w(i));
        settle();
        check("R5 ae at 2", 32'(almost_empty), 1);
        push(w(2)); settle();
        check("R5 ae off at 3", 32'(almost_empty), 0);
        for (int i = 3; i < 8; i++) push(w(i));
        settle();
        check("R4 hf off at 8", 32'(half_full), 0);
        push(w(8)); settle();
        check("R4 hf at 9", 32'(half_full), 1);
        for (int i = 9; i < 12; i++) push(w(i));
        settle();
        check("R5 af off at free 4", 32'(almost_full), 0);
        push(w(12)); settle();
        check("R5 af at free 3", 32'(almost_full), 1);
        check("R4 not full at 13", 32'(full), 0);
        for (int i = 13; i < 16; i++) push(w(i));
        settle();
        check("R4 full at 16", 32'(full), 1);
        push(18'h3FFFF); settle();
        for (int i = 0; i < 16; i++) begin
            pop(d);
            check("R3 data kept after overfill", 32'(d), 32'(w(i)));
        end
        settle();
        check("R3 empty after drain", 32'(empty), 1);
        last = rd_data;
        pop(d);
        check("R3 read on empty ignored", 32'(d), 32'(last));
        push(18'h15A5A); settle();
        pop(d);
        check("R3 next word after empty read", 32'(d), 32'h15A5A);
    endtask

    task automatic t_retx();
        logic [17:0] d, held;
        do_reset();
        for (int i = 0; i < 5; i++) push(w(i));
        settle();
        for (int i = 0; i < 3; i++) pop(d);
        check("R1 third word", 32'(d), 32'(w(2)));
        held = d;
        @(negedge rclk); rt_req = 1'b1;
        @(negedge rclk); rt_req = 1'b0;
        check("R9 empty after rewind", 32'(empty), 1);
        rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        check("R9 read suppressed", 32'(rd_data), 32'(held));
        settle();
        for (int i = 0; i < 5; i++) begin
            pop(d);
            check("R6 replay", 32'(d), 32'(w(i)));
        end
        push(w(5)); settle();
        pop(d);
        check("R6 write pointer kept", 32'(d), 32'(w(5)));
        pulse_rt(); settle();
        pop(d);
        check("R6 second replay", 32'(d), 32'(w(0)));
    endtask

    task automatic t_rt_off();
        logic [17:0] d;
        do_reset();
        rt_allow = 1'b0;
        for (int i = 0; i < 4; i++) push(w(i + 20));
        settle();
        pop(d); pop(d);
        pulse_rt(); settle();
        pop(d);
        check("R8 rt disabled", 32'(d), 32'(w(22)));
        rt_allow = 1'b1;
    endtask

    task automatic t_wrap();
        logic [17:0] d;
        do_reset();
        for (int i = 0; i < 16; i++) push(w(i + 40));
        settle();
        for (int i = 0; i < 16; i++) pop(d);
        push(18'h0AAAA); push(18'h05555); settle();
        pop(d);
        check("R7 first after wrap", 32'(d), 32'h0AAAA);
        pulse_rt(); settle();
        check("R7 not empty", 32'(empty), 0);
        pop(d);
        check("R7 rt ignored after wrap", 32'(d), 32'h05555);
    endtask

    initial begin
        t_reset();
        t_order();
        t_levels();
        t_retx();
        t_rt_off();
        t_wrap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule